// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Core

This block is a small programmable logic core built around a product-term array of 64 rows by 32 columns. Each row forms the AND of any chosen subset of 16 input signals, either true or inverted. Eight output cells each own eight rows. A cell combines its rows into a sum, can invert that sum, and can drive it straight out or through a D register. A row can also act as the cell's output enable.

A single configuration image of 2194 bits sets the whole behaviour. The image is captured in one clock cycle from a parallel port, and it is captured before the core is put to use. Two global mode bits choose one of three arrangements: simple, complex or registered. One per-cell bit then picks each cell's role inside that arrangement. The mode also decides where the feedback columns of the array take their values from. Depending on the mode, that source is a cell's own pad, a neighbouring pad, a register, or one of the two shared pins. In registered mode, one shared pin acts as the register clock enable and the other as the active-low output enable.

Top module: `pld_core`

## Requirements
- R1: On a rising `clk` edge with `cfgLoad` high, `cfgData` is stored as the configuration image. An active-low `rstN` clears the image to all zeros.
- R2: Array row r reads image bits 32r to 32r+31, and bit 32r+c controls column c. Array input k drives column 2k true and column 2k+1 inverted. A bit of 0 connects its literal and a bit of 1 leaves it out, so a row with every bit at 1 evaluates to 1. An even input k is `inPins[k/2]`. An odd input k is feedback slot (k-1)/2.
- R3: Image bit 2128+r is the disable bit of row r. When it is 1, that row contributes 0 everywhere it is used.
- R4: Image bit 2048+j is the polarity of cell j, where cell j drives `ioOut[j]`. A value of 1 passes the cell's sum or register unchanged, and a value of 0 inverts it. This holds in every mode.
- R5: The global bits sit at 2192 (S) and 2193 (A). A=0 selects simple mode. A=1 with S=0 selects registered mode. A=1 with S=1 selects complex mode.
- R6: In registered mode, a cell whose role bit (2120+j) is 0 is a D register. Its D input is the OR of all eight of its rows. It loads on a `clk` edge only while `pinClk` is 1, and it otherwise holds. Its `ioOe` is the inverse of `pinOe`, its feedback slot carries the register value, and `rstN` clears it to 0. No array column sees `pinClk` or `pinOe` in this mode.
- R7: Some cells use their first row as the output enable and OR their other seven rows as the sum. These are the cells whose role bit is 1 in registered mode, and every cell in complex mode. The feedback slot of such a cell carries its own pad input `ioIn[j]`.
- R8: In complex mode, feedback slot 0 carries `pinClk` and slot 7 carries `pinOe`, so those two pins act as ordinary data inputs.
- R9: In simple mode, a cell with role bit 0 is always enabled and ORs all eight rows, and a cell with role bit 1 has its output disabled. Cells 3 and 4 are always enabled whatever their role bit is. Slot 0 carries `pinClk` and slot 7 carries `pinOe`. Slots 1 to 3 carry `ioIn[j-1]`, and slots 4 to 6 carry `ioIn[j+1]`.
- R10: After reset, the cleared image selects simple mode with every cell enabled. Every row connects both literals of every input and so evaluates to 0, and every polarity bit is 0. As a result, `ioOut` and `ioOe` are both all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock for the image register and the cell registers |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Captures `cfgData` into the image on the next edge |
| cfgData | input | 2194 | Configuration image to be captured |
| pinClk | input | 1 | Register clock enable in registered mode, data input otherwise |
| pinOe | input | 1 | Active-low register output enable in registered mode, data input otherwise |
| inPins | input | 8 | Dedicated data inputs |
| ioIn | input | 8 | Pad input value of each cell's pin |
| ioOut | output | 8 | Output value of each cell |
| ioOe | output | 8 | Output enable of each cell |

## Verification
Several rules are checked on every cycle: image capture, the decode of the two mode bits into a mode, the hold of the cell registers when no load is enabled, the enable that `pinOe` drives on a registered cell, and the forced enables and forced disables of simple mode. Other behaviour can only be shown by the bench's scenarios with chosen images and input patterns. That covers the literal ordering of the array, row disables, polarity, the routing of feedback slots in each mode, and the toggling and capture of registered cells.

// File: rtl/pld_pkg.sv
`timescale 1ns/1ps
package pld_pkg;
  // Array geometry; the dedicated inputs equal the cell count so that
  // array inputs alternate between a dedicated pin and a feedback slot.
  localparam int NUM_MC       = 8;
  localparam int TERMS_PER_MC = 8;
  localparam int NUM_DED      = NUM_MC;
  localparam int SIG_BITS     = 64;
  localparam int HALF_MC      = NUM_MC / 2;

  localparam int NUM_IN    = NUM_DED + NUM_MC;
  localparam int NUM_COLS  = 2 * NUM_IN;
  localparam int NUM_ROWS  = NUM_MC * TERMS_PER_MC;

  // Image layout
  localparam int ARRAY_BITS = NUM_ROWS * NUM_COLS;
  localparam int POL_BASE   = ARRAY_BITS;
  localparam int AC1_BASE   = POL_BASE + NUM_MC + SIG_BITS;
  localparam int PTD_BASE   = AC1_BASE + NUM_MC;
  localparam int SYN_BIT    = PTD_BASE + NUM_ROWS;
  localparam int AC0_BIT    = SYN_BIT + 1;
  localparam int CFG_BITS   = AC0_BIT + 1;

  typedef enum logic [1:0] {
    MODE_SIMPLE     = 2'd0,
    MODE_COMPLEX    = 2'd1,
    MODE_REGISTERED = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    FB_OWN_PIN  = 3'd0,
    FB_REG      = 3'd1,
    FB_NBR_LO   = 3'd2,
    FB_NBR_HI   = 3'd3,
    FB_PIN_CLK  = 3'd4,
    FB_PIN_OE   = 3'd5
  } fb_e;

  typedef struct packed {
    mode_e                  mode;
    logic                   regLoad;
    logic [NUM_MC-1:0]      regOut;
    logic [NUM_MC-1:0]      termOe;
    logic [NUM_MC-1:0]      forceOn;
    fb_e  [NUM_MC-1:0]      fbSel;
  } ctrl_t;
endpackage

// File: rtl/pld_ctrl.sv
`timescale 1ns/1ps
module pld_ctrl
  import pld_pkg::*;
(
  input  logic              syn,
  input  logic              ac0,
  input  logic [NUM_MC-1:0] ac1,
  input  logic              pinClk,
  output ctrl_t             ctrlBus
);
  mode_e modeNow;

  always_comb begin
    if (!ac0)     modeNow = MODE_SIMPLE;
    else if (syn) modeNow = MODE_COMPLEX;
    else          modeNow = MODE_REGISTERED;
  end

  always_comb begin
    ctrlBus.mode    = modeNow;
    ctrlBus.regLoad = (modeNow == MODE_REGISTERED) && pinClk;
    for (int j = 0; j < NUM_MC; j++) begin
      ctrlBus.regOut[j]  = 1'b0;
      ctrlBus.termOe[j]  = 1'b0;
      ctrlBus.forceOn[j] = 1'b0;
      ctrlBus.fbSel[j]   = FB_OWN_PIN;
      unique case (modeNow)
        MODE_REGISTERED: begin
          ctrlBus.regOut[j] = !ac1[j];
          ctrlBus.termOe[j] = ac1[j];
          ctrlBus.fbSel[j]  = ac1[j] ? FB_OWN_PIN : FB_REG;
        end
        MODE_COMPLEX: begin
          ctrlBus.termOe[j] = 1'b1;
          if (j == 0)               ctrlBus.fbSel[j] = FB_PIN_CLK;
          else if (j == NUM_MC - 1) ctrlBus.fbSel[j] = FB_PIN_OE;
          else                      ctrlBus.fbSel[j] = FB_OWN_PIN;
        end
        default: begin
          ctrlBus.forceOn[j] = !ac1[j] || (j == HALF_MC - 1) || (j == HALF_MC);
          if (j == 0)               ctrlBus.fbSel[j] = FB_PIN_CLK;
          else if (j == NUM_MC - 1) ctrlBus.fbSel[j] = FB_PIN_OE;
          else if (j < HALF_MC)     ctrlBus.fbSel[j] = FB_NBR_LO;
          else                      ctrlBus.fbSel[j] = FB_NBR_HI;
        end
      endcase
    end
  end
endmodule

// File: rtl/pld_datapath.sv
`timescale 1ns/1ps
module pld_datapath
  import pld_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_t                 ctrlBus,
  input  logic [ARRAY_BITS-1:0] arrayBits,
  input  logic [NUM_ROWS-1:0]   ptdBits,
  input  logic [NUM_MC-1:0]     polBits,
  input  logic                  pinClk,
  input  logic                  pinOe,
  input  logic [NUM_DED-1:0]    inPins,
  input  logic [NUM_MC-1:0]     ioIn,
  output logic [NUM_MC-1:0]     ioOut,
  output logic [NUM_MC-1:0]     ioOe,
  output logic [NUM_MC-1:0]     regQ
);
  logic [NUM_MC-1:0]   slotVal;
  logic [NUM_IN-1:0]   inVec;
  logic [NUM_COLS-1:0] litVec;
  logic [NUM_ROWS-1:0] termVec;
  logic [NUM_MC-1:0]   sumAll;
  logic [NUM_MC-1:0]   sumRest;

  // Feedback slot sources
  for (genvar j = 0; j < NUM_MC; j++) begin : g_slot
    localparam int LO_IDX = (j > 0) ? j - 1 : 0;
    localparam int HI_IDX = (j < NUM_MC - 1) ? j + 1 : j;
    logic slotBit;
    always_comb begin
      unique case (ctrlBus.fbSel[j])
        FB_REG:     slotBit = regQ[j];
        FB_NBR_LO:  slotBit = ioIn[LO_IDX];
        FB_NBR_HI:  slotBit = ioIn[HI_IDX];
        FB_PIN_CLK: slotBit = pinClk;
        FB_PIN_OE:  slotBit = pinOe;
        default:    slotBit = ioIn[j];
      endcase
    end
    assign slotVal[j] = slotBit;
  end

  // Array inputs alternate dedicated pin / feedback slot
  for (genvar i = 0; i < NUM_MC; i++) begin : g_invec
    assign inVec[2*i]     = inPins[i];
    assign inVec[2*i + 1] = slotVal[i];
  end

  for (genvar k = 0; k < NUM_IN; k++) begin : g_lit
    assign litVec[2*k]     = inVec[k];
    assign litVec[2*k + 1] = ~inVec[k];
  end

  // Product terms: a cleared bit connects its literal
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign termVec[r] = (&(arrayBits[r*NUM_COLS +: NUM_COLS] | litVec)) & ~ptdBits[r];
  end

  // Output cells
  for (genvar j = 0; j < NUM_MC; j++) begin : g_cell
    logic coreVal;
    assign sumAll[j]  = |termVec[j*TERMS_PER_MC +: TERMS_PER_MC];
    assign sumRest[j] = |termVec[j*TERMS_PER_MC + 1 +: TERMS_PER_MC - 1];
    always_comb begin
      if (ctrlBus.regOut[j])      coreVal = regQ[j];
      else if (ctrlBus.termOe[j]) coreVal = sumRest[j];
      else                        coreVal = sumAll[j];
      ioOut[j] = polBits[j] ? coreVal : ~coreVal;
      if (ctrlBus.regOut[j])      ioOe[j] = ~pinOe;
      else if (ctrlBus.termOe[j]) ioOe[j] = termVec[j*TERMS_PER_MC];
      else                        ioOe[j] = ctrlBus.forceOn[j];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= '0;
    end else if (ctrlBus.regLoad) begin
      for (int j = 0; j < NUM_MC; j++) begin
        if (ctrlBus.regOut[j]) regQ[j] <= sumAll[j];
      end
    end
  end
endmodule

// File: rtl/pld_core.sv
`timescale 1ns/1ps
module pld_core
  import pld_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgLoad,
  input  logic [CFG_BITS-1:0] cfgData,
  input  logic                pinClk,
  input  logic                pinOe,
  input  logic [NUM_DED-1:0]  inPins,
  input  logic [NUM_MC-1:0]   ioIn,
  output logic [NUM_MC-1:0]   ioOut,
  output logic [NUM_MC-1:0]   ioOe
);
  logic [CFG_BITS-1:0] cfgQ;
  logic [NUM_MC-1:0]   regQ;
  ctrl_t               ctrlBus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cfgQ <= '0;
    else if (cfgLoad) cfgQ <= cfgData;
  end

  pld_ctrl u_ctrl (
    .syn     (cfgQ[SYN_BIT]),
    .ac0     (cfgQ[AC0_BIT]),
    .ac1     (cfgQ[AC1_BASE +: NUM_MC]),
    .pinClk  (pinClk),
    .ctrlBus (ctrlBus)
  );

  pld_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlBus   (ctrlBus),
    .arrayBits (cfgQ[ARRAY_BITS-1:0]),
    .ptdBits   (cfgQ[PTD_BASE +: NUM_ROWS]),
    .polBits   (cfgQ[POL_BASE +: NUM_MC]),
    .pinClk    (pinClk),
    .pinOe     (pinOe),
    .inPins    (inPins),
    .ioIn      (ioIn),
    .ioOut     (ioOut),
    .ioOe      (ioOe),
    .regQ      (regQ)
  );
endmodule

// File: rtl/pld_core_chk.sv
`timescale 1ns/1ps
module pld_core_chk
  import pld_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                cfgLoad,
  input logic [CFG_BITS-1:0] cfgData,
  input logic [CFG_BITS-1:0] cfgQ,
  input logic                pinClk,
  input logic                pinOe,
  input logic                oeCell0,
  input logic                oeInnerLo,
  input logic                oeInnerHi,
  input logic [NUM_MC-1:0]   regQ,
  input mode_e               modeCode
);
  assert_cfg_capture_R1: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> cfgQ == $past(cfgData));

  assert_simple_decode_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cfgQ[AC0_BIT] |-> modeCode == MODE_SIMPLE);

  assert_reg_decode_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ[AC0_BIT] && !cfgQ[SYN_BIT]) |-> modeCode == MODE_REGISTERED);

  assert_reg_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode != MODE_REGISTERED || !pinClk) |=> $stable(regQ));

  assert_reg_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == MODE_REGISTERED && !cfgQ[AC1_BASE]) |-> oeCell0 == !pinOe);

  assert_inner_on_R9: assert property (@(posedge clk) disable iff (!rstN)
    modeCode == MODE_SIMPLE |-> (oeInnerLo && oeInnerHi));

  assert_input_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == MODE_SIMPLE && cfgQ[AC1_BASE]) |-> !oeCell0);
endmodule

bind pld_core pld_core_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgLoad   (cfgLoad),
  .cfgData   (cfgData),
  .cfgQ      (cfgQ),
  .pinClk    (pinClk),
  .pinOe     (pinOe),
  .oeCell0   (ioOe[0]),
  .oeInnerLo (ioOe[pld_pkg::HALF_MC-1]),
  .oeInnerHi (ioOe[pld_pkg::HALF_MC]),
  .regQ      (regQ),
  .modeCode  (ctrlBus.mode)
);

// File: tb/pld_core_test.sv
`timescale 1ns/1ps
module pld_core_test;
  import pld_pkg::*;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                cfgLoad = 1'b0;
  logic [CFG_BITS-1:0] cfgData = '0;
  logic                pinClk = 1'b0;
  logic                pinOe = 1'b0;
  logic [NUM_DED-1:0]  inPins = '0;
  logic [NUM_MC-1:0]   ioIn = '0;
  logic [NUM_MC-1:0]   ioOut;
  logic [NUM_MC-1:0]   ioOe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [CFG_BITS-1:0] cfgImg;

  always #2.5 clk = ~clk;

  pld_core uut (.*);

  typedef struct packed {
    logic [7:0] inP;
    logic       clkP;
    logic       oeP;
    logic [7:0] io;
    logic [7:0] expOut;
    logic [7:0] expOe;
  } vec_t;

  // Complex-mode image (see below): out0=in0&in1, out1=in2, out2=ioIn[2],
  // out7=pinOe; oe0/oe2/oe7=1, oe1=pinClk.
  localparam vec_t CPLX_VEC [6] = '{
    '{8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h85},
    '{8'h03, 1'b1, 1'b0, 8'h00, 8'h01, 8'h87},
    '{8'h04, 1'b0, 1'b1, 8'h04, 8'h86, 8'h85},
    '{8'h07, 1'b1, 1'b1, 8'hFB, 8'h83, 8'h87},
    '{8'h01, 1'b0, 1'b0, 8'hFF, 8'h04, 8'h85},
    '{8'h06, 1'b1, 1'b1, 8'h00, 8'h82, 8'h87}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Blank image: every row unconnected and disabled, polarity high, role 0.
  task automatic blankCfg(input logic syn, input logic ac0);
    cfgImg = '0;
    cfgImg[ARRAY_BITS-1:0] = '1;
    cfgImg[PTD_BASE +: NUM_ROWS] = '1;
    cfgImg[POL_BASE +: NUM_MC] = '1;
    cfgImg[SYN_BIT] = syn;
    cfgImg[AC0_BIT] = ac0;
  endtask

  task automatic useRow(input int r);
    cfgImg[PTD_BASE + r] = 1'b0;
  endtask

  task automatic connect(input int r, input int col);
    cfgImg[r*NUM_COLS + col] = 1'b0;
  endtask

  task automatic loadCfg();
    @(negedge clk);
    cfgData = cfgImg;
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    #1;
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10 / R1: reset state
    repeat (3) @(negedge clk);
    check("R10 reset ioOut", ioOut, 8'hFF);
    check("R10 reset ioOe", ioOe, 8'hFF);
    rstN = 1'b1;
    tick();
    check("R1 cleared image ioOut", ioOut, 8'hFF);

    // Complex mode table (R2, R4, R5, R7, R8)
    blankCfg(1'b1, 1'b1);
    useRow(0);                           // cell0 enable row, unconnected -> 1
    useRow(1); connect(1, 0); connect(1, 4);   // in0 & in1
    useRow(8); connect(8, 2);            // cell1 enable = slot0 = pinClk
    useRow(9); connect(9, 9);            // ~in2
    cfgImg[POL_BASE + 1] = 1'b0;         // inverted -> in2
    useRow(16);
    useRow(17); connect(17, 10);         // slot2 = ioIn[2]
    useRow(56);
    useRow(57); connect(57, 30);         // slot7 = pinOe
    loadCfg();
    foreach (CPLX_VEC[i]) begin
      inPins = CPLX_VEC[i].inP;
      pinClk = CPLX_VEC[i].clkP;
      pinOe  = CPLX_VEC[i].oeP;
      ioIn   = CPLX_VEC[i].io;
      #1;
      check($sformatf("R2 R4 R7 R8 complex vec%0d ioOut", i), ioOut, CPLX_VEC[i].expOut);
      check($sformatf("R5 R7 R8 complex vec%0d ioOe", i), ioOe, CPLX_VEC[i].expOe);
    end

    // R3: disabling row 1 zeroes cell 0 even with in0=in1=1
    cfgImg[PTD_BASE + 1] = 1'b1;
    loadCfg();
    inPins = 8'h03; pinClk = 1'b0; pinOe = 1'b0; ioIn = 8'h00;
    #1;
    check("R3 disabled row ioOut", ioOut, 8'h00);
    check("R3 disabled row ioOe", ioOe, 8'h85);

    // Registered mode (R5, R6, R7)
    blankCfg(1'b0, 1'b1);
    cfgImg[AC1_BASE +: NUM_MC] = 8'hFC;  // cells 0,1 registered
    useRow(0); connect(0, 3);            // D0 = ~Q0 (toggle)
    useRow(8); connect(8, 0);            // D1 = in0
    cfgImg[POL_BASE + 1] = 1'b0;         // out1 = ~Q1
    useRow(16);                          // cell2 enable = 1
    useRow(17); connect(17, 6);          // slot1 = Q1
    pinClk = 1'b0; pinOe = 1'b0; inPins = 8'h00; ioIn = 8'h00;
    loadCfg();
    check("R6 registers zero after load ioOut", ioOut, 8'h02);
    check("R6 R7 registered ioOe", ioOe, 8'h07);
    pinClk = 1'b1; inPins = 8'h01;
    tick();
    check("R6 capture and toggle", ioOut, 8'h05);
    inPins = 8'h00;
    tick();
    check("R6 second capture", ioOut, 8'h02);
    pinClk = 1'b0; inPins = 8'h01;
    tick();
    check("R6 hold without enable", ioOut, 8'h02);
    pinOe = 1'b1;
    #1;
    check("R6 R7 pinOe high ioOe", ioOe, 8'h04);

    // Simple mode (R9, R4)
    blankCfg(1'b1, 1'b0);
    cfgImg[AC1_BASE + 1] = 1'b1;
    cfgImg[AC1_BASE + 3] = 1'b1;         // inner cell stays output
    cfgImg[AC1_BASE + 7] = 1'b1;
    cfgImg[POL_BASE + 3] = 1'b0;
    useRow(0); connect(0, 6);            // slot1 = ioIn[0]
    useRow(24);                          // constant 1, inverted -> 0
    useRow(32); connect(32, 2);          // slot0 = pinClk
    useRow(40); connect(40, 26);         // slot6 = ioIn[7]
    pinOe = 1'b0;
    loadCfg();
    pinClk = 1'b1; ioIn = 8'h81;
    #1;
    check("R9 simple ioOut a", ioOut, 8'h31);
    check("R9 simple ioOe", ioOe, 8'h7D);
    pinClk = 1'b0; ioIn = 8'h00;
    #1;
    check("R9 simple ioOut b", ioOut, 8'h00);
    ioIn = 8'h80;
    #1;
    check("R9 simple ioOut c", ioOut, 8'h20);

    // R1 / R10: reset clears image again
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 reset clears image ioOut", ioOut, 8'hFF);
    check("R10 reset clears image ioOe", ioOe, 8'hFF);
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule